// File: doc/BRIEF.md
# Three-Wire Clocked Serial Shifter

This block moves one byte at a time over a three-line synchronous serial link: a serial clock, a data-out line and a data-in line. The controller reaches it through a small register-write bus. One address loads the shift register. The other address holds the control bits: interface enable, transmit enable, receive enable and clock source. The controller starts a byte by loading the shift register while the interface is enabled. The block can act as master, making the serial clock from the system clock with a fixed divider. It can also act as slave, following a clock that another device drives in. In slave mode that clock passes through a synchronizer before the block uses it.

Bits go out most-significant first. Data-out changes on a falling serial-clock edge, and data-in is taken on the next rising edge. When reception is off, each bit sent is fed back into the low end of the register in place of the data-in line, so after eight shifts the register holds the byte it started with. A one-cycle interrupt pulse marks each completed byte. If the controller clears the interface enable mid-byte, the transfer stops at once, later clock edges do nothing and no pulse is raised.

The shifter is a three-state machine. `ST_IDLE` leaves on a start (a data write while enabled) to `ST_WAIT_FALL`. `ST_WAIT_FALL` moves on a falling edge with transmit enabled to `ST_WAIT_RISE`, putting the current top bit on data-out. `ST_WAIT_RISE` shifts on a rising edge with transmit enabled. From there it returns to `ST_WAIT_FALL`, or to `ST_IDLE` with the interrupt pulse after the eighth bit. From either active state, a cleared enable leads to `ST_IDLE` (abort), and a fresh start leads back to `ST_WAIT_FALL` (restart).

Top module: `sync_serial_port`

## Requirements
- R1: A transfer starts only on a data write (`bus_addr_i`=0) while control bit 0 (enable) is 1. A data write while enable is 0 loads the register, raises no busy and leaves the serial clock high.
- R2: Bits are sent MSB first. Data-out takes the next bit on a falling serial-clock edge. Data-in is shifted into bit 0 on the following rising edge when control bit 2 (receive enable) is 1.
- R3: With receive enable 0, each sent bit is fed into bit 0 instead of data-in, so after eight shifts the register again holds the written byte.
- R4: `irq_o` is high for exactly one system cycle, on the cycle in which the eighth rising edge is taken. Each completed byte gives exactly one pulse.
- R5: In master mode (control bit 3 = 0) the serial clock idles high, each half period lasts HALF_DIV system cycles, and the first falling edge comes at most 2*HALF_DIV cycles after the start write. `sck_oe_o` is 1 in master mode and 0 in slave mode.
- R6: In slave mode (control bit 3 = 1), clock edges that arrive while no transfer has been started cause no shifting, and data-out keeps its level.
- R7: Clearing enable during a transfer returns the block to idle in the next cycle. Later clock edges change neither data-out nor the register, and no interrupt pulse is raised.
- R8: While control bit 1 (transmit enable) is 0, clock edges cause no shifting and data-out holds its level, while busy stays high.
- R9: `busy_o` is high from the cycle after the start write until the eighth rising edge is taken, and `shift_q_o` always shows the current register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 1 | 0 selects shift register, 1 selects control |
| bus_wdata_i | input | BITS | Write data; control uses bits 3..0 |
| shift_q_o | output | BITS | Current shift register contents |
| busy_o | output | 1 | Transfer in progress |
| irq_o | output | 1 | End-of-byte pulse |
| sck_i | input | 1 | Serial clock in (slave mode) |
| sck_o | output | 1 | Serial clock out (master mode) |
| sck_oe_o | output | 1 | Serial clock output enable |
| sd_o | output | 1 | Serial data out |
| sd_i | input | 1 | Serial data in |

## Verification
A wrong state would show up quickly at the ports. A stuck `ST_WAIT_RISE` or a bad bit count would show as a missing or extra interrupt pulse and a busy flag that never falls, within one byte time. A wrong shift direction or a loopback mux on the wrong input changes `shift_q_o` after the first rising edge, and the register compare at the end of the byte catches it. A leaked edge in an idle, aborted or transmit-disabled state moves data-out or the register within one synchronizer delay of that edge. The bench reads both back before the next stimulus.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_FALL = 2'd1,
        ST_WAIT_RISE = 2'd2
    } sh_state_t;

    localparam int CTL_EN  = 0;
    localparam int CTL_TX  = 1;
    localparam int CTL_RX  = 2;
    localparam int CTL_EXT = 3;
endpackage

// File: rtl/ssp_sync_edge.sv
module ssp_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-1:0], sck_i};
    end

    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall_o = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sck_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          sck_q;
    logic          tick;

    assign tick   = run_i && (cnt_q == LAST);
    assign fall_o = tick & sck_q;
    assign rise_o = tick & ~sck_q;
    assign sck_o  = sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sck_q <= 1'b1;
        end else if (!run_i) begin
            cnt_q <= '0;
            sck_q <= 1'b1;
        end else if (tick) begin
            cnt_q <= '0;
            sck_q <= ~sck_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ssp_core.sv
module ssp_core
    import ssp_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            tx_en_i,
    input  logic            rx_en_i,
    input  logic            load_i,
    input  logic [BITS-1:0] load_data_i,
    input  logic            fall_i,
    input  logic            rise_i,
    input  logic            sd_i,
    output logic [BITS-1:0] shreg_o,
    output logic            sd_o,
    output logic            busy_o,
    output logic            irq_o
);
    localparam int CNT_W = (BITS > 1) ? $clog2(BITS) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BITS - 1);

    sh_state_t       state_q, state_d;
    logic [BITS-1:0] shreg_q;
    logic [CNT_W-1:0] bit_q;
    logic            so_q, irq_q;
    logic            start, do_fall, do_rise, last;

    assign start   = load_i && en_i;
    assign do_fall = (state_q == ST_WAIT_FALL) && fall_i && tx_en_i && en_i && !load_i;
    assign do_rise = (state_q == ST_WAIT_RISE) && rise_i && tx_en_i && en_i && !load_i;
    assign last    = (bit_q == LAST_BIT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_WAIT_FALL;
            end
            ST_WAIT_FALL: begin
                if (!en_i)        state_d = ST_IDLE;
                else if (start)   state_d = ST_WAIT_FALL;
                else if (do_fall) state_d = ST_WAIT_RISE;
            end
            ST_WAIT_RISE: begin
                if (!en_i)        state_d = ST_IDLE;
                else if (start)   state_d = ST_WAIT_FALL;
                else if (do_rise) state_d = last ? ST_IDLE : ST_WAIT_FALL;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            bit_q   <= '0;
            so_q    <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= do_rise && last;
            if (load_i) begin
                shreg_q <= load_data_i;
                bit_q   <= '0;
            end else if (do_fall) begin
                so_q <= shreg_q[BITS-1];
            end else if (do_rise) begin
                shreg_q <= {shreg_q[BITS-2:0], rx_en_i ? sd_i : so_q};
                bit_q   <= bit_q + 1'b1;
            end
        end
    end

    assign shreg_o = shreg_q;
    assign sd_o    = so_q;
    assign busy_o  = (state_q != ST_IDLE);
    assign irq_o   = irq_q;
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
    import ssp_pkg::*;
#(
    parameter int BITS        = 8,
    parameter int HALF_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_we_i,
    input  logic            bus_addr_i,
    input  logic [BITS-1:0] bus_wdata_i,
    output logic [BITS-1:0] shift_q_o,
    output logic            busy_o,
    output logic            irq_o,
    input  logic            sck_i,
    output logic            sck_o,
    output logic            sck_oe_o,
    output logic            sd_o,
    input  logic            sd_i
);
    logic ctl_en_q, ctl_tx_q, ctl_rx_q, ctl_ext_q;
    logic ext_rise, ext_fall, int_rise, int_fall;
    logic gen_run, busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_en_q  <= 1'b0;
            ctl_tx_q  <= 1'b0;
            ctl_rx_q  <= 1'b0;
            ctl_ext_q <= 1'b0;
        end else if (bus_we_i && bus_addr_i) begin
            ctl_en_q  <= bus_wdata_i[CTL_EN];
            ctl_tx_q  <= bus_wdata_i[CTL_TX];
            ctl_rx_q  <= bus_wdata_i[CTL_RX];
            ctl_ext_q <= bus_wdata_i[CTL_EXT];
        end
    end

    assign gen_run = busy && ctl_en_q && !ctl_ext_q;

    ssp_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck_i(sck_i),
        .rise_o(ext_rise), .fall_o(ext_fall)
    );

    ssp_clkgen #(.HALF_DIV(HALF_DIV)) u_gen (
        .clk(clk), .rst_n(rst_n), .run_i(gen_run),
        .sck_o(sck_o), .rise_o(int_rise), .fall_o(int_fall)
    );

    ssp_core #(.BITS(BITS)) u_core (
        .clk(clk), .rst_n(rst_n),
        .en_i(ctl_en_q), .tx_en_i(ctl_tx_q), .rx_en_i(ctl_rx_q),
        .load_i(bus_we_i && !bus_addr_i), .load_data_i(bus_wdata_i),
        .fall_i(ctl_ext_q ? ext_fall : int_fall),
        .rise_i(ctl_ext_q ? ext_rise : int_rise),
        .sd_i(sd_i), .shreg_o(shift_q_o), .sd_o(sd_o),
        .busy_o(busy), .irq_o(irq_o)
    );

    assign busy_o   = busy;
    assign sck_oe_o = !ctl_ext_q;
endmodule

// File: rtl/ssp_chk.sv
module ssp_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_we_i,
    input logic bus_addr_i,
    input logic en_q,
    input logic tx_q,
    input logic busy_o,
    input logic irq_o,
    input logic sck_o,
    input logic sd_o
);
    // R1
    start_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(bus_we_i && !bus_addr_i && en_q));
    // R4
    irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    // R5
    sck_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> sck_o);
    // R7
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (!busy_o && !irq_o));
    // R8
    tx_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_q |=> $stable(sd_o));
    // R9
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (irq_o || !$past(en_q)));
endmodule

bind sync_serial_port ssp_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .en_q(ctl_en_q), .tx_q(ctl_tx_q), .busy_o(busy_o), .irq_o(irq_o),
    .sck_o(sck_o), .sd_o(sd_o)
);

// File: tb/sync_serial_port_tb.sv
`timescale 1ns/1ps
module sync_serial_port_tb;
    localparam int BITS = 8;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_we = 1'b0, bus_addr = 1'b0;
    logic [BITS-1:0] bus_wdata = '0;
    logic [BITS-1:0] shift_q;
    logic busy, irq, sck_o, sck_oe, sd_o;
    logic sck_i = 1'b1, sd_i = 1'b0;
    int total = 0, fails = 0, irq_cnt = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sync_serial_port #(.BITS(BITS), .HALF_DIV(HALF), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .shift_q_o(shift_q), .busy_o(busy), .irq_o(irq),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe_o(sck_oe), .sd_o(sd_o), .sd_i(sd_i)
    );

    always @(posedge clk) if (rst_n && irq) irq_cnt++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic addr, input logic [BITS-1:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = addr; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic ext_half(input logic lvl);
        @(negedge clk);
        sck_i = lvl;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R9 busy reset", busy, 0);
        chk("R4 irq reset", irq, 0);
        chk("R5 sck idle", sck_o, 1);
        chk("R9 shift reset", shift_q, 0);
    endtask

    task automatic t_master(input logic rx, input logic [7:0] tx_b, input logic [7:0] rx_b);
        logic [7:0] got;
        int cyc;
        wr(1'b1, {4'b0, 1'b0, rx, 1'b1, 1'b1});
        chk("R5 sck_oe master", sck_oe, 1);
        irq_cnt = 0;
        wr(1'b0, tx_b);
        chk("R9 busy after start", busy, 1);
        cyc = 1;
        while (sck_o && cyc < 40) begin @(negedge clk); cyc++; end
        chk("R5 first fall latency", (cyc <= 2*HALF), 1);
        for (int i = 0; i < 8; i++) begin
            if (sck_o) @(negedge sck_o);
            #1 sd_i = rx_b[7-i];
            @(posedge sck_o);
            #1 got[7-i] = sd_o;
            if (i == 7) begin
                chk("R4 irq on last rise", irq, 1);
                chk("R9 busy ends last rise", busy, 0);
            end
        end
        repeat (3) @(negedge clk);
        chk("R2 msb first out", got, tx_b);
        chk(rx ? "R2 captured byte" : "R3 byte preserved", shift_q, rx ? rx_b : tx_b);
        chk("R4 one pulse", irq_cnt, 1);
        chk("R5 sck idle after", sck_o, 1);
    endtask

    task automatic t_disabled_write;
        wr(1'b1, 8'h06);
        wr(1'b0, 8'h5E);
        repeat (20) @(negedge clk);
        chk("R1 no busy when disabled", busy, 0);
        chk("R1 sck stays high", sck_o, 1);
        chk("R1 data loaded", shift_q, 8'h5E);
    endtask

    task automatic t_slave_idle_edges;
        logic so0;
        wr(1'b1, 8'h0E);
        wr(1'b0, 8'h81);
        wr(1'b1, 8'h0F);
        chk("R5 sck_oe slave", sck_oe, 0);
        so0 = sd_o;
        irq_cnt = 0;
        for (int i = 0; i < 6; i++) begin ext_half(1'b0); ext_half(1'b1); end
        chk("R6 so held", sd_o, so0);
        chk("R6 no shift", shift_q, 8'h81);
        chk("R6 no busy", busy, 0);
        chk("R6 no irq", irq_cnt, 0);
    endtask

    task automatic t_slave(input logic [7:0] tx_b, input logic [7:0] rx_b);
        logic [7:0] got;
        wr(1'b1, 8'h0F);
        irq_cnt = 0;
        wr(1'b0, tx_b);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); sck_i = 1'b0; sd_i = rx_b[7-i];
            repeat (6) @(negedge clk);
            got[7-i] = sd_o;
            ext_half(1'b1);
        end
        chk("R2 slave msb first", got, tx_b);
        chk("R2 slave captured", shift_q, rx_b);
        chk("R4 slave one pulse", irq_cnt, 1);
        chk("R9 slave busy done", busy, 0);
    endtask

    task automatic t_abort;
        logic so0;
        logic [7:0] q0;
        wr(1'b1, 8'h0F);
        irq_cnt = 0;
        wr(1'b0, 8'hF0);
        for (int i = 0; i < 3; i++) begin ext_half(1'b0); ext_half(1'b1); end
        wr(1'b1, 8'h0E);
        @(negedge clk);
        chk("R7 idle after abort", busy, 0);
        so0 = sd_o; q0 = shift_q;
        for (int i = 0; i < 6; i++) begin ext_half(1'b0); ext_half(1'b1); end
        chk("R7 so held", sd_o, so0);
        chk("R7 register held", shift_q, q0);
        chk("R7 no irq", irq_cnt, 0);
    endtask

    task automatic t_tx_off;
        logic so0;
        wr(1'b1, 8'h0D);
        irq_cnt = 0;
        so0 = sd_o;
        wr(1'b0, 8'h3C);
        for (int i = 0; i < 8; i++) begin ext_half(1'b0); ext_half(1'b1); end
        chk("R8 so held", sd_o, so0);
        chk("R8 no shift", shift_q, 8'h3C);
        chk("R8 still busy", busy, 1);
        chk("R8 no irq", irq_cnt, 0);
        wr(1'b1, 8'h0C);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_master(1'b1, 8'hA5, 8'h3C);
        t_master(1'b0, 8'h96, 8'hFF);
        t_disabled_write();
        t_slave_idle_edges();
        t_slave(8'hC3, 8'h5A);
        t_abort();
        t_tx_off();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule